// File: doc/BRIEF.md
# Debug Address Translation Probe

This block is a register-mapped debug unit placed next to a translation buffer unit. Software uses it to ask how one virtual address translates for a chosen stream ID. First it stops client traffic, then it waits until the in-flight client transactions have drained. After that it loads the stream ID and the virtual address and fires a single read or write probe. The probe carries cache and protection attributes.

The engine sends exactly one request on a valid/ready request port to an external page-walk responder and captures the reply. The result word holds the physical page number and a fault flag. A running flag lets software poll for completion. A built-in timer makes sure every probe ends in bounded time. A one-bit availability semaphore lets several software agents take turns using the engine.

The register bus is a plain single-cycle bus. Read data is combinational from the address. Writes and read side effects take place at the clock edge on which the strobe is high.

Top module: `dxp_engine`

## Requirements
- R1: After reset, status (0x20) reads 0, the result (0x28) reads 0, the semaphore (0x30) reads 1 on its first read, `cli_block` is 0 and `wk_req_valid` is 0.
- R2: Bit 16 of register 0x00 requests a halt, and `cli_block` follows it. Status bit 1 (halt acknowledge) rises only once the count of outstanding client transactions is zero. It is still 1 in the cycle right after the halt bit is cleared and is 0 from the cycle after that. Client issues are not counted while `cli_block` is high.
- R3: A write to 0x18 with bit 0 set is ignored, and no request is issued, when the halt is not acknowledged or when a probe is already running.
- R4: Status bit 0 (running) is 1 in the cycle after an accepted trigger. It returns to 0 once the probe completes.
- R5: The request carries the stream ID from bits 9:0 of 0x00 and the address from 0x08. From the trigger word it takes the direction (bit 1, 1 = write), the cache attributes (bits 5:2) and the protection attributes (bits 8:6). `wk_req_valid` stays high with stable fields until `wk_req_ready`.
- R6: On a clean reply the result reads the physical page number in bits 47:12 with bit 0 clear. On a faulting reply it reads exactly 1, with the address field cleared.
- R7: If no reply arrives within 1024 cycles of the accepted trigger, the probe completes with the result reading exactly 1.
- R8: A read of 0x30 that returns 1 takes the semaphore, and later reads return 0. Writing 0 to 0x30 frees it again.
- R9: Registers 0x08 and 0x18 read back their last written value (for 0x18 only bits 8:1; bit 0 reads 0). Writing 0 to either clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` |
| cli_issue | input | 1 | A client transaction starts |
| cli_retire | input | 1 | A client transaction completes |
| cli_block | output | 1 | Halt request toward the client path |
| wk_req_valid | output | 1 | Walk request valid |
| wk_req_ready | input | 1 | Walk request accepted |
| wk_req_sid | output | 10 | Stream ID of the request |
| wk_req_va | output | 48 | Virtual address of the request |
| wk_req_write | output | 1 | Direction, 1 = write |
| wk_req_cache | output | 4 | Cache attributes |
| wk_req_prot | output | 3 | Protection attributes |
| wk_rsp_valid | input | 1 | Walk reply valid |
| wk_rsp_pa | input | 36 | Physical page number of the reply |
| wk_rsp_fault | input | 1 | The reply reports a fault |

## Verification
If the outstanding-client count is wrong, the halt acknowledge either never rises or rises while transactions are still in flight. Either way, status bit 1 shows it within a cycle of the last retire. A stuck or wrongly sequenced walk state shows up as a running bit that never falls, or as a repeated `wk_req_valid` after completion. Either shows within a few cycles of the reply, or at the latest at the 1024-cycle timeout. Corrupted latched fields show on the request port the moment `wk_req_valid` rises. They show in the result word on the first read after completion.

// File: rtl/dxp_pkg.sv
package dxp_pkg;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 8;

  // register offsets (byte addresses)
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_VA   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_PAR  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_SEM  = 8'h30;

  // field positions
  localparam int HALT_BIT   = 16;
  localparam int DIR_BIT    = 1;
  localparam int CACHE_LSB  = 2;
  localparam int CACHE_W    = 4;
  localparam int PROT_LSB   = 6;
  localparam int PROT_W     = 3;
  localparam int PAR_PA_LSB = 12;

  typedef enum logic [1:0] {WK_IDLE, WK_ISSUE, WK_WAIT} wk_state_e;

  // result word: page number at PAR_PA_LSB, fault flag at bit 0
  function automatic logic [DATA_W-1:0] pack_par(input logic [DATA_W-1:0] pa,
                                                 input logic fault);
    logic [DATA_W-1:0] w;
    if (fault) w = {{(DATA_W-1){1'b0}}, 1'b1};
    else       w = pa << PAR_PA_LSB;
    return w;
  endfunction
endpackage

// File: rtl/dxp_halt_ctl.sv
module dxp_halt_ctl #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic cli_issue,
  input  logic cli_retire,
  output logic cli_block,
  output logic halt_ack,
  output logic [CNT_W-1:0] outstanding
);
  logic inc, dec;

  assign cli_block = halt_req;
  assign inc = cli_issue && !halt_req;
  assign dec = cli_retire && (outstanding != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= '0;
      halt_ack    <= 1'b0;
    end else begin
      if (inc && !dec)      outstanding <= outstanding + 1'b1;
      else if (dec && !inc) outstanding <= outstanding - 1'b1;
      halt_ack <= halt_req && (outstanding == '0);
    end
  end

  p_ack_drained_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ack |-> (outstanding == '0));
  p_ack_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |=> !halt_ack);
endmodule

// File: rtl/dxp_sem.sv
module dxp_sem (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic free
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          free <= 1'b1;
    else if (give)       free <= 1'b1;
    else if (take)       free <= 1'b0;
  end

  p_sem_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && free && !give) |=> !free);
endmodule

// File: rtl/dxp_walk_fsm.sv
module dxp_walk_fsm
  import dxp_pkg::*;
#(
  parameter int SID_W   = 10,
  parameter int VA_W    = 48,
  parameter int PA_W    = 36,
  parameter int TMO_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic [SID_W-1:0] st_sid,
  input  logic [VA_W-1:0]  st_va,
  input  logic             st_write,
  input  logic [CACHE_W-1:0] st_cache,
  input  logic [PROT_W-1:0]  st_prot,
  output logic busy,
  output logic done,
  output logic [DATA_W-1:0] par,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [SID_W-1:0]   req_sid,
  output logic [VA_W-1:0]    req_va,
  output logic               req_write,
  output logic [CACHE_W-1:0] req_cache,
  output logic [PROT_W-1:0]  req_prot,
  input  logic               rsp_valid,
  input  logic [PA_W-1:0]    rsp_pa,
  input  logic               rsp_fault
);
  localparam int TMR_W = $clog2(TMO_CYC + 1);

  wk_state_e state;
  logic [TMR_W-1:0] timer;
  logic tmo_hit, rsp_hit;

  assign busy      = (state != WK_IDLE);
  assign req_valid = (state == WK_ISSUE);
  assign rsp_hit   = (state == WK_WAIT) && rsp_valid;
  assign tmo_hit   = busy && (timer == TMR_W'(TMO_CYC - 1));
  assign done      = rsp_hit || tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WK_IDLE;
      timer     <= '0;
      par       <= '0;
      req_sid   <= '0;
      req_va    <= '0;
      req_write <= 1'b0;
      req_cache <= '0;
      req_prot  <= '0;
    end else begin
      case (state)
        WK_IDLE: if (start) begin
          state     <= WK_ISSUE;
          timer     <= '0;
          req_sid   <= st_sid;
          req_va    <= st_va;
          req_write <= st_write;
          req_cache <= st_cache;
          req_prot  <= st_prot;
        end
        WK_ISSUE: if (req_ready) state <= WK_WAIT;
        default: ;
      endcase
      if (busy) timer <= timer + 1'b1;
      if (done) begin
        state <= WK_IDLE;
        if (rsp_hit) par <= pack_par(DATA_W'(rsp_pa), rsp_fault);
        else         par <= pack_par('0, 1'b1);
      end
    end
  end

  p_run_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !done) |=> req_valid && $stable(req_va) && $stable(req_sid));
  p_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (timer < TMR_W'(TMO_CYC)));
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/dxp_engine.sv
module dxp_engine
  import dxp_pkg::*;
#(
  parameter int SID_W   = 10,
  parameter int VA_W    = 48,
  parameter int PA_W    = 36,
  parameter int TMO_CYC = 1024,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               cli_issue,
  input  logic               cli_retire,
  output logic               cli_block,
  output logic               wk_req_valid,
  input  logic               wk_req_ready,
  output logic [SID_W-1:0]   wk_req_sid,
  output logic [VA_W-1:0]    wk_req_va,
  output logic               wk_req_write,
  output logic [CACHE_W-1:0] wk_req_cache,
  output logic [PROT_W-1:0]  wk_req_prot,
  input  logic               wk_rsp_valid,
  input  logic [PA_W-1:0]    wk_rsp_pa,
  input  logic               wk_rsp_fault
);
  localparam int TRIG_W = PROT_LSB + PROT_W;

  logic [SID_W-1:0]  sid_q;
  logic              halt_q;
  logic [VA_W-1:0]   va_q;
  logic [TRIG_W-1:1] trig_q;
  logic halt_ack, busy, done, sem_free;
  logic [CNT_W-1:0] outstanding;
  logic [DATA_W-1:0] par;
  logic wr_ctrl, wr_va, wr_trig, wr_sem, rd_sem, trig_req, start;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_va    = bus_wr && (bus_addr == OFS_VA);
  assign wr_trig  = bus_wr && (bus_addr == OFS_TRIG);
  assign wr_sem   = bus_wr && (bus_addr == OFS_SEM) && (bus_wdata == '0);
  assign rd_sem   = bus_rd && (bus_addr == OFS_SEM);
  assign trig_req = wr_trig && bus_wdata[0];
  assign start    = trig_req && halt_ack && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sid_q  <= '0;
      halt_q <= 1'b0;
      va_q   <= '0;
      trig_q <= '0;
    end else begin
      if (wr_ctrl) begin
        sid_q  <= bus_wdata[SID_W-1:0];
        halt_q <= bus_wdata[HALT_BIT];
      end
      if (wr_va)   va_q   <= bus_wdata[VA_W-1:0];
      if (wr_trig) trig_q <= bus_wdata[TRIG_W-1:1];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[SID_W-1:0] = sid_q;
        bus_rdata[HALT_BIT]  = halt_q;
      end
      OFS_VA:   bus_rdata[VA_W-1:0] = va_q;
      OFS_TRIG: bus_rdata[TRIG_W-1:1] = trig_q;
      OFS_STAT: bus_rdata[1:0] = {halt_ack, busy};
      OFS_PAR:  bus_rdata = par;
      OFS_SEM:  bus_rdata[0] = sem_free;
      default:  bus_rdata = '0;
    endcase
  end

  dxp_halt_ctl #(.CNT_W(CNT_W)) u_halt (
    .clk, .rst_n, .halt_req(halt_q), .cli_issue, .cli_retire,
    .cli_block, .halt_ack, .outstanding
  );

  dxp_sem u_sem (.clk, .rst_n, .take(rd_sem), .give(wr_sem), .free(sem_free));

  dxp_walk_fsm #(.SID_W(SID_W), .VA_W(VA_W), .PA_W(PA_W), .TMO_CYC(TMO_CYC)) u_walk (
    .clk, .rst_n, .start,
    .st_sid(sid_q), .st_va(va_q), .st_write(bus_wdata[DIR_BIT]),
    .st_cache(bus_wdata[CACHE_LSB +: CACHE_W]), .st_prot(bus_wdata[PROT_LSB +: PROT_W]),
    .busy, .done, .par,
    .req_valid(wk_req_valid), .req_ready(wk_req_ready), .req_sid(wk_req_sid),
    .req_va(wk_req_va), .req_write(wk_req_write), .req_cache(wk_req_cache),
    .req_prot(wk_req_prot), .rsp_valid(wk_rsp_valid), .rsp_pa(wk_rsp_pa),
    .rsp_fault(wk_rsp_fault)
  );

  p_trig_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && (!halt_ack || busy)) |=> $stable(wk_req_sid) && !$rose(wk_req_valid));
  p_fault_no_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    par[0] |-> (par[DATA_W-1:1] == '0));
  p_ack_only_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ack |-> $past(halt_q));
endmodule

// File: tb/dxp_engine_test.sv
module dxp_engine_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic cli_issue = 0, cli_retire = 0, cli_block;
  logic wk_req_valid, wk_req_ready = 0, wk_req_write;
  logic [9:0] wk_req_sid;
  logic [47:0] wk_req_va;
  logic [3:0] wk_req_cache;
  logic [2:0] wk_req_prot;
  logic wk_rsp_valid = 0, wk_rsp_fault = 0;
  logic [35:0] wk_rsp_pa = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  dxp_engine uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #2; d = bus_rdata;
    @(posedge clk); #1; bus_rd = 0;
  endtask

  function automatic logic [35:0] model_pa(input logic [47:0] va, input logic [9:0] sid);
    return va[47:12] ^ {26'h0, sid};
  endfunction

  function automatic logic [63:0] model_par(input logic [35:0] pa, input bit f);
    logic [63:0] r = '0;
    if (f) r[0] = 1'b1; else r[47:12] = pa;
    return r;
  endfunction

  function automatic logic [63:0] trig_word(input bit w, input logic [3:0] c, input logic [2:0] p);
    return {55'h0, p, c, w, 1'b1};
  endfunction

  task automatic halt_on;
    logic [63:0] d;
    int n = 0;
    do begin rd(8'h20, d); n++; end while (!d[1] && n < 20);
    chk(d[1] == 1'b1, "R2 ack", d, 64'h2);
  endtask

  // one full probe; silent = responder never answers
  task automatic probe(input logic [9:0] sid, input logic [47:0] va, input bit w,
                       input logic [3:0] c, input logic [2:0] p, input int rdy_dly,
                       input int lat, input bit f, input bit silent, input bit retrig);
    logic [63:0] d;
    logic [35:0] pa;
    int n;
    wr(8'h00, 64'h10000 | sid);
    halt_on();
    wr(8'h08, {16'h0, va});
    wr(8'h18, trig_word(w, c, p));
    rd(8'h20, d);
    chk(d[0] == 1'b1, "R4 running after trigger", d, 64'h3);
    if (retrig) wr(8'h18, trig_word(~w, ~c, ~p));
    if (silent) begin
      n = 0;
      do begin rd(8'h20, d); n++; end while (d[0] && n < 1200);
      chk(n > 1000 && n < 1040, "R7 timeout window", 64'(n), 64'd1024);
      rd(8'h28, d);
      chk(d == 64'h1, "R7 timeout result", d, 64'h1);
    end else begin
      @(negedge clk);
      chk(wk_req_valid && wk_req_sid == sid && wk_req_va == va && wk_req_write == w
          && wk_req_cache == c && wk_req_prot == p, "R5 request fields",
          {wk_req_sid, wk_req_va, 6'b0}, {sid, va, 6'b0});
      repeat (rdy_dly) @(negedge clk);
      chk(wk_req_valid && wk_req_va == va, "R5 request held", 64'(wk_req_va), 64'(va));
      wk_req_ready = 1;
      @(posedge clk); #1; wk_req_ready = 0;
      repeat (lat) @(posedge clk);
      pa = model_pa(va, sid);
      @(negedge clk); wk_rsp_valid = 1; wk_rsp_pa = pa; wk_rsp_fault = f;
      @(posedge clk); #1; wk_rsp_valid = 0; wk_rsp_fault = 0;
      rd(8'h20, d);
      chk(d[0] == 1'b0, "R4 running cleared", d, 64'h2);
      rd(8'h28, d);
      chk(d == model_par(pa, f), "R6 result word", d, model_par(pa, f));
      if (retrig) begin
        repeat (3) begin
          @(negedge clk);
          chk(!wk_req_valid, "R3 retrigger while running ignored", 64'(wk_req_valid), 64'h0);
        end
      end
    end
    wr(8'h18, 64'h0);
    wr(8'h08, 64'h0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(8'h20, d); chk(d == 0, "R1 status", d, 0);
    rd(8'h28, d); chk(d == 0, "R1 result", d, 0);
    chk(!cli_block && !wk_req_valid, "R1 outputs", {cli_block, wk_req_valid}, 0);
    rd(8'h30, d); chk(d == 1, "R1 semaphore", d, 1);

    // R8 semaphore
    rd(8'h30, d); chk(d == 0, "R8 taken", d, 0);
    rd(8'h30, d); chk(d == 0, "R8 still taken", d, 0);
    wr(8'h30, 64'h0);
    rd(8'h30, d); chk(d == 1, "R8 released", d, 1);
    rd(8'h30, d); chk(d == 0, "R8 retaken", d, 0);
    wr(8'h30, 64'h0);

    // R3 trigger without halt ack
    wr(8'h00, 64'h5);
    wr(8'h18, trig_word(0, 4'hf, 3'h3));
    rd(8'h20, d); chk(d[0] == 0, "R3 no ack trigger ignored", d, 0);
    chk(!wk_req_valid, "R3 no request", 64'(wk_req_valid), 0);

    // R2 drain of outstanding client transactions
    repeat (3) begin @(negedge clk); cli_issue = 1; @(posedge clk); #1 cli_issue = 0; end
    wr(8'h00, 64'h10005);
    chk(cli_block == 1, "R2 block follows halt", 64'(cli_block), 1);
    @(negedge clk); cli_issue = 1; @(posedge clk); #1 cli_issue = 0; // blocked, not counted
    repeat (2) begin @(negedge clk); cli_retire = 1; @(posedge clk); #1 cli_retire = 0; end
    repeat (3) @(posedge clk);
    rd(8'h20, d); chk(d[1] == 0, "R2 no ack while outstanding", d, 0);
    @(negedge clk); cli_retire = 1; @(posedge clk); #1 cli_retire = 0;
    repeat (2) @(posedge clk);
    rd(8'h20, d); chk(d[1] == 1, "R2 ack after drain", d, 2);
    wr(8'h00, 64'h5);
    rd(8'h20, d); chk(d[1] == 1, "R2 ack one cycle after clear", d, 2);
    rd(8'h20, d); chk(d[1] == 0, "R2 ack dropped", d, 0);

    // R9 readback and clearing
    wr(8'h08, 64'h0000_1234_5678_9abc);
    rd(8'h08, d); chk(d == 64'h0000_1234_5678_9abc, "R9 va readback", d, 64'h0000_1234_5678_9abc);
    wr(8'h08, 0); rd(8'h08, d); chk(d == 0, "R9 va cleared", d, 0);
    wr(8'h18, 64'h1d6);  // no start bit
    rd(8'h18, d); chk(d == 64'h1d6, "R9 trigger readback", d, 64'h1d6);
    rd(8'h20, d); chk(d[0] == 0, "R3 bit0 clear no start", d, 0);
    wr(8'h18, 0); rd(8'h18, d); chk(d == 0, "R9 trigger cleared", d, 0);

    // directed probes
    probe(10'h3ff, 48'hffff_ffff_f000, 1, 4'hf, 3'h3, 0, 0, 0, 0, 0);
    probe(10'h000, 48'h0000_0000_1000, 0, 4'h0, 3'h0, 3, 4, 1, 0, 1);
    probe(10'h155, 48'h0123_4567_8000, 1, 4'ha, 3'h5, 1, 2, 0, 1, 0);
    rd(8'h18, d); chk(d == 0, "R9 trigger cleared after probe", d, 0);

    // random probes
    for (int i = 0; i < 24; i++) begin
      probe(10'($urandom), {$urandom, $urandom}[47:0], 1'($urandom), 4'($urandom),
            3'($urandom), int'($urandom % 4), int'($urandom % 6),
            ($urandom % 4) == 0, 0, ($urandom % 3) == 0);
    end

    wr(8'h00, 64'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule